// File: doc/BRIEF.md
# Timer Reset Condition Detector

This block turns one of six external signals into a reset request for a free-running hardware limit timer. A 3-bit selector picks the source. Two enables decide whether the high/rising polarity, the low/falling polarity, or both may cause a reset. Each polarity has its own mode bit that makes it either edge-triggered or level-triggered. All sources pass through a two-flop synchronizer into the timer clock domain, so any reset the block produces takes effect on a timer clock edge and never asynchronously.

A detected edge sets a pending latch. The latch holds its request until the timer consumes it on a tick. A level condition drives the request for as long as the condition holds. A write to the timer counter takes precedence over any reset. It masks the request in the cycle of the write and clears the pending latch. A write to the control fields blocks edge detection for that cycle, so changing the selector or the modes cannot create a false edge.

Top module: `tmr_rst_cond`

## Requirements
- R1: Select codes 0 to 5 on `sel_i` choose `src_i[sel_i]` as the reset source. The other five source bits have no effect on `rst_req_o`.
- R2: Select codes 6 and 7 choose no source. With either code selected, no level request and no edge event is ever produced.
- R3: When `rise_en_i`=1 and `rise_edge_i`=0, `rst_req_o` is 1 while the synchronized source is 1.
- R4: When `fall_en_i`=1 and `fall_edge_i`=0, `rst_req_o` is 1 while the synchronized source is 0.
- R5: When `rise_en_i`=1 and `rise_edge_i`=1, a 0-to-1 source transition sets a pending request. The request is seen on `rst_req_o` after the third rising clock edge that follows the input change. A steady source or a 1-to-0 transition produces no request.
- R6: When `fall_en_i`=1 and `fall_edge_i`=1, a 1-to-0 source transition sets a pending request with the same latency as R5. A 0-to-1 transition produces no request.
- R7: A pending request holds until a clock edge at which `tick_i`=1, and that edge clears it. If a new edge event occurs in that same cycle, the request stays set.
- R8: While `cnt_wr_i`=1, `rst_req_o` is 0 in that same cycle, whatever the level or pending state. The pending request is cleared at that clock edge, and this takes precedence over a new edge event and over `tick_i`.
- R9: In a cycle with `cfg_wr_i`=1, no edge event is detected. Changing the selector onto a source of a different value during such a write leaves no pending request.
- R10: After `rst_ni` is asserted, the synchronizers and the pending latch are 0, and `rst_req_o` is 0 while both enables are 0.
- R11: A level request follows a source change after two rising clock edges. It does not follow the source at the first edge.
- R12: With both enables at 0, no source activity produces a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 6 | Asynchronous reset source signals |
| sel_i | input | 3 | Source select, codes 6 and 7 mean no source |
| rise_en_i | input | 1 | Enable for the high/rising polarity |
| rise_edge_i | input | 1 | 1 makes the rising polarity edge-triggered, 0 makes it high-level |
| fall_en_i | input | 1 | Enable for the low/falling polarity |
| fall_edge_i | input | 1 | 1 makes the falling polarity edge-triggered, 0 makes it low-level |
| cfg_wr_i | input | 1 | Control write strobe, blocks edge detection for this cycle |
| tick_i | input | 1 | Timer tick that consumes the pending request |
| cnt_wr_i | input | 1 | Counter write strobe, cancels any request |
| rst_req_o | output | 1 | Reset request to the timer |

## Verification
A table of level-mode vectors drives each polarity against a source that is held high and held low. In each vector the selected bit is set opposite to the other bits, so a wrong mux index or a leaked neighbour shows up as a flipped result. The table also covers both unused codes, with every source bit at the level that would otherwise trigger. Directed sequences then apply rising and falling transitions in edge mode. These sequences check that the request appears on the third edge and not the second, that the opposite transition is ignored, and that the request holds until a tick. Counter writes are placed against pending and level requests to show their precedence. A selector change during a control write is used to show that the write creates no false edge.

// File: rtl/tmr_rst_pkg.sv
package tmr_rst_pkg;
  localparam int unsigned NUM_SRC = 6;
  localparam int unsigned SEL_W   = 3;

  typedef struct packed {
    logic rise_en;
    logic rise_edge;
    logic fall_en;
    logic fall_edge;
  } pol_cfg_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/tmr_rst_qual.sv
module tmr_rst_qual
  import tmr_rst_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  sync_i,
  input  logic [SW-1:0] sel_i,
  input  pol_cfg_t      cfg_i,
  input  logic          cfg_wr_i,
  output logic          evt_o,
  output logic          lvl_o
);
  logic valid, cur, prev_q;
  logic rise_e, fall_e, rise_l, fall_l;

  assign valid = (32'(sel_i) < N);
  assign cur   = valid ? sync_i[sel_i] : 1'b0;

  // previous sample follows the mux every cycle; a control write also reloads it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= cur;
  end

  assign rise_e = valid && !cfg_wr_i && cfg_i.rise_en && cfg_i.rise_edge &&  cur && !prev_q;
  assign fall_e = valid && !cfg_wr_i && cfg_i.fall_en && cfg_i.fall_edge && !cur &&  prev_q;
  assign rise_l = valid && cfg_i.rise_en && !cfg_i.rise_edge &&  cur;
  assign fall_l = valid && cfg_i.fall_en && !cfg_i.fall_edge && !cur;

  assign evt_o = rise_e | fall_e;
  assign lvl_o = rise_l | fall_l;
endmodule

// File: rtl/tmr_rst_pend.sv
module tmr_rst_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic tick_i,
  input  logic cnt_wr_i,
  output logic pend_o
);
  logic pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (cnt_wr_i) pend_q <= 1'b0;
    else if (evt_i)    pend_q <= 1'b1;
    else if (tick_i)   pend_q <= 1'b0;
  end
  assign pend_o = pend_q;
endmodule

// File: rtl/tmr_rst_cond.sv
module tmr_rst_cond
  import tmr_rst_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned SW = SEL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  src_i,
  input  logic [SW-1:0] sel_i,
  input  logic          rise_en_i,
  input  logic          rise_edge_i,
  input  logic          fall_en_i,
  input  logic          fall_edge_i,
  input  logic          cfg_wr_i,
  input  logic          tick_i,
  input  logic          cnt_wr_i,
  output logic          rst_req_o
);
  logic [N-1:0] sync_w;
  logic         evt_w, lvl_w, pend_w;
  pol_cfg_t     cfg_w;

  assign cfg_w = '{rise_en: rise_en_i, rise_edge: rise_edge_i,
                   fall_en: fall_en_i, fall_edge: fall_edge_i};

  tmr_rst_sync #(.W(N)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (src_i), .q_o (sync_w)
  );

  tmr_rst_qual #(.N(N), .SW(SW)) u_qual (
    .clk_i (clk_i), .rst_ni (rst_ni), .sync_i (sync_w), .sel_i (sel_i),
    .cfg_i (cfg_w), .cfg_wr_i (cfg_wr_i), .evt_o (evt_w), .lvl_o (lvl_w)
  );

  tmr_rst_pend u_pend (
    .clk_i (clk_i), .rst_ni (rst_ni), .evt_i (evt_w), .tick_i (tick_i),
    .cnt_wr_i (cnt_wr_i), .pend_o (pend_w)
  );

  // counter write has precedence over any reset source
  assign rst_req_o = (pend_w | lvl_w) & ~cnt_wr_i;
endmodule

// File: rtl/tmr_rst_cond_chk.sv
module tmr_rst_cond_chk #(
  parameter int unsigned N  = 6,
  parameter int unsigned SW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [SW-1:0] sel_i,
  input logic          cfg_wr_i,
  input logic          tick_i,
  input logic          cnt_wr_i,
  input logic          rst_req_o,
  input logic          pend_w,
  input logic          evt_w
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  AST_WR_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |-> !rst_req_o); // R8

  AST_WR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> !pend_w); // R8

  AST_NO_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && (32'(sel_i) >= N) && (32'($past(sel_i)) >= N) && !$past(rst_req_o)
      |-> !rst_req_o); // R2

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_w && !tick_i && !cnt_wr_i |=> pend_w); // R7

  AST_TICK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_w && tick_i && !cnt_wr_i && !evt_w |=> !pend_w); // R7

  AST_CFG_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr_i && !pend_w |=> !pend_w); // R9
endmodule

bind tmr_rst_cond tmr_rst_cond_chk #(.N(N), .SW(SW)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .sel_i (sel_i), .cfg_wr_i (cfg_wr_i),
  .tick_i (tick_i), .cnt_wr_i (cnt_wr_i), .rst_req_o (rst_req_o),
  .pend_w (pend_w), .evt_w (evt_w)
);

// File: tb/tmr_rst_cond_tb.sv
module tmr_rst_cond_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] src_i = '0;
  logic [2:0] sel_i = '0;
  logic       rise_en_i = 0, rise_edge_i = 0, fall_en_i = 0, fall_edge_i = 0;
  logic       cfg_wr_i = 0, tick_i = 0, cnt_wr_i = 0;
  logic       rst_req_o;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #2.5 clk_i = ~clk_i;

  tmr_rst_cond u_dut (.*);

  // {sel[2:0], src[5:0], rise_en, rise_edge, fall_en, fall_edge, expected}
  localparam int NV = 12;
  localparam logic [13:0] VEC [NV] = '{
    {3'd0, 6'b000001, 4'b1000, 1'b1},  // R1 R3
    {3'd0, 6'b111110, 4'b1000, 1'b0},  // R1 R3
    {3'd5, 6'b100000, 4'b1000, 1'b1},  // R1
    {3'd5, 6'b011111, 4'b1000, 1'b0},  // R1
    {3'd2, 6'b111011, 4'b0010, 1'b1},  // R4
    {3'd2, 6'b000100, 4'b0010, 1'b0},  // R4
    {3'd6, 6'b111111, 4'b1010, 1'b0},  // R2
    {3'd7, 6'b000000, 4'b1010, 1'b0},  // R2
    {3'd3, 6'b001000, 4'b1100, 1'b0},  // R5 steady
    {3'd1, 6'b111111, 4'b0000, 1'b0},  // R12
    {3'd4, 6'b010000, 4'b1010, 1'b1},  // R3 R4
    {3'd4, 6'b000000, 4'b1010, 1'b1}   // R3 R4
  };

  task automatic chk(input logic exp, input string req);
    n_chk++;
    if (rst_req_o !== exp) begin
      n_fail++;
      $display("FAIL %s: rst_req_o=%b expected %b", req, rst_req_o, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic cfg(input logic [2:0] s, input logic [3:0] m);
    sel_i = s;
    {rise_en_i, rise_edge_i, fall_en_i, fall_edge_i} = m;
    cfg_wr_i = 1;
    cyc(1);
    cfg_wr_i = 0;
  endtask

  task automatic flush();
    tick_i = 1; cyc(1); tick_i = 0;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(2);
    #1 chk(1'b0, "R10 in reset");
    rst_ni = 1;
    cyc(2);
    chk(1'b0, "R10 after reset");

    // table walk: level conditions
    for (int i = 0; i < NV; i++) begin
      src_i = VEC[i][10:5];
      cfg(VEC[i][13:11], VEC[i][4:1]);
      cyc(4);
      flush();
      chk(VEC[i][0], $sformatf("R1/R2/R3/R4 vector %0d", i));
    end

    // R11: level latency two edges
    src_i = 6'b0; cfg(3'd0, 4'b1000); cyc(4); flush();
    src_i = 6'b000001;
    cyc(1); chk(1'b0, "R11 one edge");
    cyc(1); chk(1'b1, "R11 two edges");

    // R5: rising edge, latency three edges, holds until tick
    src_i = 6'b0; cfg(3'd0, 4'b1100); cyc(4); flush();
    src_i = 6'b000001;
    cyc(2); chk(1'b0, "R5 before third edge");
    cyc(1); chk(1'b1, "R5 third edge");
    cyc(5); chk(1'b1, "R5 hold");
    tick_i = 1; #1 chk(1'b1, "R7 before tick edge");
    cyc(1); tick_i = 0; #1 chk(1'b0, "R7 tick clears");
    src_i = 6'b0; cyc(5); chk(1'b0, "R5 falling ignored");

    // R6: falling edge
    src_i = 6'b000001; cfg(3'd0, 4'b0011); cyc(4); flush();
    src_i = 6'b0;
    cyc(2); chk(1'b0, "R6 before third edge");
    cyc(1); chk(1'b1, "R6 third edge");
    flush();
    src_i = 6'b000001; cyc(5); chk(1'b0, "R6 rising ignored");

    // R8: counter write cancels pending
    src_i = 6'b0; cyc(4); chk(1'b1, "R8 setup pending");
    cnt_wr_i = 1; tick_i = 0; #1 chk(1'b0, "R8 mask same cycle");
    cyc(1); cnt_wr_i = 0; #1 chk(1'b0, "R8 pending cleared");

    // R8: counter write masks level
    src_i = 6'b000001; cfg(3'd0, 4'b1000); cyc(4);
    chk(1'b1, "R8 level setup");
    cnt_wr_i = 1; #1 chk(1'b0, "R8 level masked");
    cyc(1); cnt_wr_i = 0; #1 chk(1'b1, "R8 level resumes");

    // R9: control write onto a high source creates no edge
    src_i = 6'b000010; cfg(3'd0, 4'b1100); cyc(4); flush();
    chk(1'b0, "R9 setup");
    cfg(3'd1, 4'b1100);
    cyc(4); chk(1'b0, "R9 no false edge");

    // R2: no-source code with toggling sources in edge mode
    cfg(3'd6, 4'b1111); cyc(4); flush();
    src_i = 6'b111111; cyc(4); src_i = 6'b0; cyc(4);
    chk(1'b0, "R2 edges ignored");

    // R10: reset clears pending
    cfg(3'd0, 4'b1100); cyc(4); flush();
    src_i = 6'b000001; cyc(3); chk(1'b1, "R10 setup");
    rst_ni = 0; rise_en_i = 0; #1 chk(1'b0, "R10 reset clears");
    cyc(1); rst_ni = 1; cyc(1); chk(1'b0, "R10 after release");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule